// File: doc/BRIEF.md
# Watchdog Configuration Unlock Gate

This block stands between a 16-bit register write bus and the configuration registers of a watchdog timer. Every configuration write is held back unless a timed window is open. The window opens only when the unlock address receives two key words in a row, first 0xC520 and then 0xD928. It then stays open for a fixed number of bus clock cycles and closes by itself.

While the window is open, the block passes writes to the protected registers as single-cycle write enables. The control word is stored here. It can be written only once in each window. Its allow-update bit acts as a sticky lock: once that bit is 0, no later key sequence opens a window, and only the power-on reset input clears the lock. An ordinary system reset closes the window and drops a half-entered key, but the stored control word survives it.

The block also keeps its own copy of the timeout value. It raises a flag whenever that value is too short for the unlock window.

Top module: `wdg_cfg_gate`

## Requirements
- R1: After power-on reset, ctrl_word is 0x00D3, with the enable, clock source, allow-update, stop and wait bits set. cfg_open and cfg_err are 0, and every write enable is 0.
- R2: A write of 0xC520 to address 6 followed by a write of 0xD928 to address 6, with no other write between them, sets cfg_open from the next cycle. This holds only while ctrl_word bit 4 (allow update) is 1.
- R3: If the second key word is not 0xD928, the sequence returns to idle and no window opens. A write to any other address between the two key words has the same effect.
- R4: The window stays open for exactly WIN_CYCLES (default 256) bus cycles after the edge on which the second key is taken, then closes. A new valid key pair restarts it.
- R5: While cfg_open is 0, writes to addresses 0 to 5 produce no write enable and leave ctrl_word and cfg_err unchanged.
- R6: The control register (address 0) accepts one write per window: ctrl_we pulses for the first write only, and later writes in that window leave ctrl_word unchanged. A new window allows one more write.
- R7: Control layout: bit0 enable, bit1 clock select, bit2 interrupt enable, bit3 window mode, bit4 allow update, bit5 run in debug, bit6 run in stop, bit7 run in wait, bit10 test enable, bit11 test select (0 quick, 1 byte), bits 13:12 test byte select, bit14 test disable. The reserved bits 9:8 and 15 always read 0.
- R8: When ctrl_word bit 4 is 0, a valid key pair does not open the window and no write enable pulses. The same holds inside the window in which the bit was cleared, for every cycle after the write that cleared it.
- R9: While the window is open and bit 4 is 1, a write asserts its enable in the same cycle: tmo_hi_we for address 1, tmo_lo_we for address 2, win_hi_we for address 3, win_lo_we for address 4, presc_we for address 5.
- R10: After each accepted timeout write, cfg_err becomes 1 if the timeout {hi,lo} is at most 2*WIN_CYCLES+20 (532 by default), and 0 otherwise. The stored timeout resets to 0x0001_0000.
- R11: A low rst_n closes the window, clears the key sequence and re-arms the write-once rule, but keeps ctrl_word and cfg_err. A low por_n restores every R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| por_n | input | 1 | Synchronous power-on reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address (0 ctrl, 1/2 timeout hi/lo, 3/4 window hi/lo, 5 prescaler, 6 unlock) |
| bus_wdata | input | 16 | Write data |
| ctrl_word | output | 16 | Stored control word |
| ctrl_we | output | 1 | Control write accepted |
| tmo_hi_we | output | 1 | Timeout high half write enable |
| tmo_lo_we | output | 1 | Timeout low half write enable |
| win_hi_we | output | 1 | Window value high half write enable |
| win_lo_we | output | 1 | Window value low half write enable |
| presc_we | output | 1 | Prescaler write enable |
| cfg_open | output | 1 | Configuration window open |
| cfg_err | output | 1 | Stored timeout too short for the unlock window |

## Verification
The hardest state to reach is a sticky lock set from inside an open window. That state has to survive a system reset and then be cleared only by power-on reset. The stimulus opens a window and writes a control word with bit 4 cleared. It then tries protected writes in the same window, lets the window run out, and retries the key pair. Next it pulses rst_n and retries once more, and finally pulses por_n and checks that a key pair opens the window again. A behavioural model is compared with the design on every cycle. It also covers the exact closing cycle of the 256-cycle window and a break in the key pair caused by a write to another address.

// File: rtl/wdg_gate_pkg.sv
package wdg_gate_pkg;
  localparam int ADDR_W = 3;
  localparam logic [15:0] KEY_FIRST  = 16'hC520;
  localparam logic [15:0] KEY_SECOND = 16'hD928;
  localparam logic [15:0] CTRL_KEEP_MASK = 16'h7CFF;
  localparam logic [15:0] CTRL_DEFAULT   = 16'h00D3;
  localparam int ALLOW_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_TMO_HI = 3'd1,
    RA_TMO_LO = 3'd2,
    RA_WIN_HI = 3'd3,
    RA_WIN_LO = 3'd4,
    RA_PRESC  = 3'd5,
    RA_UNLOCK = 3'd6
  } reg_addr_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } seq_e;
endpackage

// File: rtl/wdg_unlock_seq.sv
module wdg_unlock_seq
  import wdg_gate_pkg::*;
#(
  parameter int WIN_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              allow,
  output logic              open,
  output logic              reopen
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  seq_e          seq_q;
  logic [CW-1:0] left_q;
  logic          to_unlock;

  assign to_unlock = wr && (addr == RA_UNLOCK);
  assign reopen    = to_unlock && (seq_q == SEQ_HALF) && (wdata == KEY_SECOND) && allow;
  assign open      = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      seq_q <= SEQ_IDLE;
    end else if (wr) begin
      if (to_unlock && seq_q == SEQ_IDLE && wdata == KEY_FIRST)
        seq_q <= SEQ_HALF;
      else
        seq_q <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n)
      left_q <= '0;
    else if (reopen)
      left_q <= CW'(WIN_CYCLES);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        wr_ok,
  input  logic        reopen,
  input  logic [15:0] wdata,
  output logic [15:0] ctrl_word,
  output logic        ctrl_we
);
  logic done_q;

  assign ctrl_we = wr_ok && !done_q;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n)
      done_q <= 1'b0;
    else if (reopen)
      done_q <= 1'b0;
    else if (ctrl_we)
      done_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n)
      ctrl_word <= CTRL_DEFAULT;
    else if (ctrl_we)
      ctrl_word <= wdata & CTRL_KEEP_MASK;
  end
endmodule

// File: rtl/wdg_tmo_check.sv
module wdg_tmo_check #(
  parameter int WIN_CYCLES = 256,
  parameter int SLACK = 20,
  parameter logic [31:0] TMO_DEFAULT = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        hi_we,
  input  logic        lo_we,
  input  logic [15:0] wdata,
  output logic        cfg_err
);
  localparam logic [31:0] LIMIT = 32'(2 * WIN_CYCLES + SLACK);

  logic [31:0] tmo_q;
  logic [31:0] tmo_next;

  always_comb begin
    tmo_next = tmo_q;
    if (hi_we) tmo_next[31:16] = wdata;
    if (lo_we) tmo_next[15:0]  = wdata;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      tmo_q   <= TMO_DEFAULT;
      cfg_err <= 1'b0;
    end else if (hi_we || lo_we) begin
      tmo_q   <= tmo_next;
      cfg_err <= (tmo_next <= LIMIT);
    end
  end
endmodule

// File: rtl/wdg_cfg_gate.sv
module wdg_cfg_gate
  import wdg_gate_pkg::*;
#(
  parameter int WIN_CYCLES = 256,
  parameter int SLACK = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       ctrl_word,
  output logic              ctrl_we,
  output logic              tmo_hi_we,
  output logic              tmo_lo_we,
  output logic              win_hi_we,
  output logic              win_lo_we,
  output logic              presc_we,
  output logic              cfg_open,
  output logic              cfg_err
);
  localparam int N_PROT = 6;

  logic              reopen;
  logic              allow;
  logic              accept;
  logic [N_PROT-1:0] hit;

  assign allow  = ctrl_word[ALLOW_BIT];
  assign accept = bus_wr && cfg_open && allow;

  for (genvar g = 0; g < N_PROT; g++) begin : g_dec
    assign hit[g] = accept && (bus_addr == ADDR_W'(g));
  end

  assign tmo_hi_we = hit[RA_TMO_HI];
  assign tmo_lo_we = hit[RA_TMO_LO];
  assign win_hi_we = hit[RA_WIN_HI];
  assign win_lo_we = hit[RA_WIN_LO];
  assign presc_we  = hit[RA_PRESC];

  wdg_unlock_seq #(.WIN_CYCLES(WIN_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .allow(allow), .open(cfg_open), .reopen(reopen)
  );

  wdg_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr_ok(hit[RA_CTRL]), .reopen(reopen), .wdata(bus_wdata),
    .ctrl_word(ctrl_word), .ctrl_we(ctrl_we)
  );

  wdg_tmo_check #(.WIN_CYCLES(WIN_CYCLES), .SLACK(SLACK)) u_tmo (
    .clk(clk), .por_n(por_n),
    .hi_we(tmo_hi_we), .lo_we(tmo_lo_we), .wdata(bus_wdata),
    .cfg_err(cfg_err)
  );
endmodule

// File: rtl/wdg_cfg_gate_chk.sv
module wdg_cfg_gate_chk
  import wdg_gate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       ctrl_word,
  input logic              ctrl_we,
  input logic              tmo_hi_we,
  input logic              tmo_lo_we,
  input logic              win_hi_we,
  input logic              win_lo_we,
  input logic              presc_we,
  input logic              cfg_open
);
  // R5: no enable while closed
  assert_closed_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !cfg_open |-> !(ctrl_we || tmo_hi_we || tmo_lo_we || win_hi_we || win_lo_we || presc_we));

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !$past(ctrl_we) |-> $stable(ctrl_word));

  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(cfg_open) |-> $past(bus_wr && bus_addr == RA_UNLOCK && bus_wdata == KEY_SECOND));

  assert_lock_blocks_open_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(cfg_open) |-> $past(ctrl_word[ALLOW_BIT]));

  assert_ctrl_once_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctrl_we |=> !ctrl_we);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
    ctrl_word[9:8] == 2'b00 && !ctrl_word[15]);
endmodule

bind wdg_cfg_gate wdg_cfg_gate_chk chk_i (.*);

// File: tb/wdg_cfg_gate_test.sv
module wdg_cfg_gate_test;
  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] ctrl_word;
  logic        ctrl_we, tmo_hi_we, tmo_lo_we, win_hi_we, win_lo_we, presc_we;
  logic        cfg_open, cfg_err;

  always #2 clk = ~clk;

  wdg_cfg_gate uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_word(ctrl_word),
    .ctrl_we(ctrl_we), .tmo_hi_we(tmo_hi_we), .tmo_lo_we(tmo_lo_we),
    .win_hi_we(win_hi_we), .win_lo_we(win_lo_we), .presc_we(presc_we),
    .cfg_open(cfg_open), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_ctrl;
  logic [31:0] m_tmo;
  bit          m_err, m_half, m_done;
  int          m_left;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit w, input int a, input int d);
    bit acc;
    acc = w && (m_left > 0) && m_ctrl[4];
    if (!por_n) begin
      m_ctrl = 16'h00D3; m_tmo = 32'h0001_0000; m_err = 0;
      m_half = 0; m_left = 0; m_done = 0;
    end else if (!rst_n) begin
      m_half = 0; m_left = 0; m_done = 0;
    end else begin
      bit opened = 0;
      if (w && a == 6) begin
        if (m_half && d == 16'hD928 && m_ctrl[4]) opened = 1;
        m_half = !m_half && (d == 16'hC520);
      end else if (w) begin
        m_half = 0;
      end
      if (acc) begin
        if (a == 0 && !m_done) begin m_ctrl = d[15:0] & 16'h7CFF; m_done = 1; end
        if (a == 1) begin m_tmo[31:16] = d[15:0]; m_err = (m_tmo <= 532); end
        if (a == 2) begin m_tmo[15:0]  = d[15:0]; m_err = (m_tmo <= 532); end
      end
      if (opened) begin m_left = 256; m_done = 0; end
      else if (m_left > 0) m_left--;
    end
  endtask

  task automatic step(input bit w, input int a, input int d, input string tag);
    bit acc;
    bus_wr = w; bus_addr = a[2:0]; bus_wdata = d[15:0];
    #1;
    acc = w && (m_left > 0) && m_ctrl[4];
    chk(tag, "ctrl_we",   int'(ctrl_we),   int'(acc && a == 0 && !m_done));
    chk(tag, "tmo_hi_we", int'(tmo_hi_we), int'(acc && a == 1));
    chk(tag, "tmo_lo_we", int'(tmo_lo_we), int'(acc && a == 2));
    chk(tag, "win_hi_we", int'(win_hi_we), int'(acc && a == 3));
    chk(tag, "win_lo_we", int'(win_lo_we), int'(acc && a == 4));
    chk(tag, "presc_we",  int'(presc_we),  int'(acc && a == 5));
    @(posedge clk);
    model_edge(w, a, d);
    @(negedge clk);
    chk(tag, "ctrl_word", int'(ctrl_word), int'(m_ctrl));
    chk(tag, "cfg_open",  int'(cfg_open),  int'(m_left > 0));
    chk(tag, "cfg_err",   int'(cfg_err),   int'(m_err));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  task automatic unlock(input string tag);
    step(1, 6, 16'hC520, tag);
    step(1, 6, 16'hD928, tag);
  endtask

  initial begin
    por_n = 0; rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_ctrl = 0; m_tmo = 0; m_err = 0; m_half = 0; m_done = 0; m_left = 0;
    @(negedge clk);
    idle(3, "R1");
    por_n = 1; rst_n = 1;
    idle(2, "R1");
    // R5: closed-window writes are dropped
    for (int a = 0; a < 6; a++) step(1, a, 16'h0000, "R5");
    // R3: wrong second word, then interrupted pair
    step(1, 6, 16'hC520, "R3"); step(1, 6, 16'h1234, "R3"); step(1, 6, 16'hD928, "R3");
    step(1, 6, 16'hC520, "R3"); step(1, 2, 16'h0001, "R3"); step(1, 6, 16'hD928, "R3");
    step(1, 6, 16'hC520, "R3"); step(1, 6, 16'hC520, "R3"); step(1, 6, 16'hD928, "R3");
    idle(2, "R3");
    // R2: valid pair opens
    unlock("R2");
    // R7: reserved bits dropped
    step(1, 0, 16'hFFF3, "R7");
    // R6: second control write ignored
    step(1, 0, 16'h0013, "R6");
    // R10: timeout limit corner values
    step(1, 1, 16'h0000, "R10");
    step(1, 2, 16'h0200, "R10");
    step(1, 2, 16'h0215, "R10");
    step(1, 2, 16'h0214, "R10");
    step(1, 1, 16'h0001, "R10");
    // R9: remaining enables
    step(1, 3, 16'h00AA, "R9"); step(1, 4, 16'h0055, "R9"); step(1, 5, 16'h0003, "R9");
    // R4: run the window out and past its end
    idle(250, "R4");
    step(1, 1, 16'h0000, "R5"); step(1, 2, 16'h0010, "R5");
    // R6: new window re-arms; clear allow update (R8)
    unlock("R6");
    step(1, 0, 16'h00C3, "R6");
    step(1, 2, 16'h0000, "R8"); step(1, 5, 16'h0001, "R8"); step(1, 0, 16'h00D3, "R8");
    idle(255, "R4");
    unlock("R8");
    idle(2, "R8");
    // R11: system reset keeps lock
    rst_n = 0; idle(2, "R11"); rst_n = 1;
    unlock("R11");
    idle(2, "R11");
    // R11: power-on reset restores defaults
    por_n = 0; idle(2, "R11"); por_n = 1;
    idle(1, "R11");
    unlock("R11");
    step(1, 0, 16'h00D1, "R11");
    // R4: restart within an open window
    idle(100, "R4");
    unlock("R4");
    idle(258, "R4");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule